// File: doc/BRIEF.md
# Three-Sample Bang-Bang Phase Decision

This block holds the decision logic of an early/late phase detector in a clock and data recovery loop. For each bit period it takes three synchronous samples of the incoming stream: one at the bit centre, one at the point where the next edge is expected, and one at the centre of the bit after that. From these it makes a ternary decision: retard the clock, advance it, or do nothing. It also puts out the retimed data bit and a flag that marks whether a data transition took place.

The loop uses the advance and retard pulses to nudge the oscillator phase by a fixed step. A frequency acquisition aid drives a correction-enable input low while the oscillator is outside its capture window. While that input is low, the block issues no corrections. Data retiming and transition reporting keep running while corrections are suspended. All outputs are registered and appear one clock after the samples that produced them.

Top module: `alex_pd_top`

## Requirements
- R1: While rst_ni is low, up_o, dn_o, data_o and edge_o are all 0.
- R2: If the centre sample equals the following-centre sample (samp_a_i == samp_b_i), neither up_o nor dn_o is raised in the next cycle, whatever samp_t_i is.
- R3: If samp_t_i equals samp_a_i and differs from samp_b_i, and corr_en_i is 1, dn_o is 1 in the next cycle. This case means the clock is early.
- R4: If samp_t_i equals samp_b_i and differs from samp_a_i, and corr_en_i is 1, up_o is 1 in the next cycle. This case means the clock is late.
- R5: Each correction lasts exactly one cycle per sample set. A pulse is held in a later cycle only when that cycle's own samples call for it again.
- R6: data_o equals samp_a_i from the previous cycle.
- R7: When corr_en_i is 0, up_o and dn_o are both 0 in the next cycle. data_o and edge_o are unaffected.
- R8: up_o and dn_o are never 1 in the same cycle.
- R9: edge_o equals (samp_a_i != samp_b_i) from the previous cycle, whatever the value of corr_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_a_i | input | 1 | Sample at the centre of the current bit |
| samp_t_i | input | 1 | Sample at the expected transition point |
| samp_b_i | input | 1 | Sample at the centre of the following bit |
| corr_en_i | input | 1 | 1 allows corrections; 0 suspends them during frequency acquisition |
| up_o | output | 1 | Advance pulse (clock late) |
| dn_o | output | 1 | Retard pulse (clock early) |
| data_o | output | 1 | Retimed data bit |
| edge_o | output | 1 | A transition was seen between the centre samples |

## Verification
Every output is a one-cycle-delayed function of the inputs. Any wrong decision, such as an inverted early/late mapping, a missing enable gate or a stale register, therefore shows at the ports in the very next cycle. The bench sweeps all eight sample combinations with the enable both high and low, so each wrong entry in the decision table is hit. Long random runs then catch a pulse that persists or data that slips by a cycle.

// File: rtl/alex_pd_pkg.sv
package alex_pd_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } dir_e;

  typedef struct packed {
    dir_e dir;
    logic data;
    logic edge_seen;
  } decision_t;
endpackage

// File: rtl/alex_pd_classify.sv
module alex_pd_classify
  import alex_pd_pkg::*;
(
  input  logic      a_i,
  input  logic      t_i,
  input  logic      b_i,
  input  logic      en_i,
  output decision_t dec_o
);
  logic trans;
  dir_e raw_dir;

  assign trans = a_i ^ b_i;

  always_comb begin
    raw_dir = DIR_NONE;
    if (trans) begin
      // with a != b, t matches exactly one side
      if (t_i == a_i) raw_dir = DIR_DN;
      else            raw_dir = DIR_UP;
    end
  end

  always_comb begin
    dec_o.dir       = en_i ? raw_dir : DIR_NONE;
    dec_o.data      = a_i;
    dec_o.edge_seen = trans;
  end
endmodule

// File: rtl/alex_pd_retime.sv
module alex_pd_retime
  import alex_pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  decision_t dec_i,
  output logic      up_o,
  output logic      dn_o,
  output logic      data_o,
  output logic      edge_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o   <= 1'b0;
      dn_o   <= 1'b0;
      data_o <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      up_o   <= (dec_i.dir == DIR_UP);
      dn_o   <= (dec_i.dir == DIR_DN);
      data_o <= dec_i.data;
      edge_o <= dec_i.edge_seen;
    end
  end
endmodule

// File: rtl/alex_pd_top.sv
module alex_pd_top
  import alex_pd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic samp_a_i,
  input  logic samp_t_i,
  input  logic samp_b_i,
  input  logic corr_en_i,
  output logic up_o,
  output logic dn_o,
  output logic data_o,
  output logic edge_o
);
  decision_t dec;

  alex_pd_classify u_classify (
    .a_i  (samp_a_i),
    .t_i  (samp_t_i),
    .b_i  (samp_b_i),
    .en_i (corr_en_i),
    .dec_o(dec)
  );

  alex_pd_retime u_retime (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dec_i (dec),
    .up_o  (up_o),
    .dn_o  (dn_o),
    .data_o(data_o),
    .edge_o(edge_o)
  );
endmodule

// File: rtl/alex_pd_chk.sv
module alex_pd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic samp_a_i,
  input logic samp_t_i,
  input logic samp_b_i,
  input logic corr_en_i,
  input logic up_o,
  input logic dn_o,
  input logic data_o,
  input logic edge_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!up_o && !dn_o && !data_o && !edge_o));

  assert_no_corr_same_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_a_i == samp_b_i) |=> (!up_o && !dn_o));

  assert_early_dn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_en_i && samp_t_i == samp_a_i && samp_t_i != samp_b_i) |=> dn_o);

  assert_late_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_en_i && samp_t_i == samp_b_i && samp_t_i != samp_a_i) |=> up_o);

  assert_data_retime_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> (data_o == $past(samp_a_i)));

  assert_disable_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_en_i |=> (!up_o && !dn_o));

  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  assert_edge_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> (edge_o == $past(samp_a_i ^ samp_b_i)));
endmodule

bind alex_pd_top alex_pd_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .samp_a_i (samp_a_i),
  .samp_t_i (samp_t_i),
  .samp_b_i (samp_b_i),
  .corr_en_i(corr_en_i),
  .up_o     (up_o),
  .dn_o     (dn_o),
  .data_o   (data_o),
  .edge_o   (edge_o)
);

// File: tb/alex_pd_top_tb_top.sv
module alex_pd_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, t = 1'b0, b = 1'b0, en = 1'b0;
  logic up, dn, dat, edg;
  int   n_chk = 0;
  int   n_err = 0;
  logic pa, pt, pb, pen;

  always #10 clk = ~clk;

  alex_pd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .samp_a_i(a), .samp_t_i(t), .samp_b_i(b), .corr_en_i(en),
    .up_o(up), .dn_o(dn), .data_o(dat), .edge_o(edg)
  );

  function automatic logic exp_up(logic ea, logic et, logic eb, logic ee);
    return ee && (ea != eb) && (et == eb);
  endfunction
  function automatic logic exp_dn(logic ea, logic et, logic eb, logic ee);
    return ee && (ea != eb) && (et == ea);
  endfunction

  task automatic chk(string req, logic act, logic expv, string what);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, expv);
    end
  endtask

  // drive at negedge; outputs then reflect previous drive
  task automatic step(logic na, logic nt, logic nb, logic ne);
    @(negedge clk);
    a = na; t = nt; b = nb; en = ne;
    pa = na; pt = nt; pb = nb; pen = ne;
    @(posedge clk);
    @(negedge clk);
    chk((pa == pb) ? "R2" : (pen ? ((pt == pa) ? "R3" : "R4") : "R7"),
        up, exp_up(pa, pt, pb, pen), "up_o");
    chk((pa == pb) ? "R2" : (pen ? ((pt == pa) ? "R3" : "R4") : "R7"),
        dn, exp_dn(pa, pt, pb, pen), "dn_o");
    chk("R6", dat, pa, "data_o");
    chk("R9", edg, pa ^ pb, "edge_o");
    chk("R8", up & dn, 1'b0, "up_o&dn_o");
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd1357;
    void'($urandom(seed));
    a = 1'b1; t = 1'b1; b = 1'b0; en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", up, 1'b0, "up_o in reset");
    chk("R1", dn, 1'b0, "dn_o in reset");
    chk("R1", dat, 1'b0, "data_o in reset");
    chk("R1", edg, 1'b0, "edge_o in reset");
    rst_n = 1'b1;

    // directed: every combination, enable high then low
    for (int e = 1; e >= 0; e--)
      for (int k = 0; k < 8; k++)
        step(k[2], k[1], k[0], e[0]);

    // R5: repeated late then a no-action sample: pulse must drop
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5", up, 1'b0, "up_o after quiet sample");
    step(1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5", dn, 1'b0, "dn_o after quiet sample");

    // random mix, enable mostly high
    for (int i = 0; i < 2000; i++)
      step(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) != 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule